// File: doc/BRIEF.md
# Supply Voltage Monitor Reset Logic

This block turns a stream of sampled supply-level codes into an active-high initial reset request. An external comparator stage produces a 2-bit level code. A separate timer decides when each sample is taken, and a one-cycle strobe marks each sample. The block counts a run of consecutive samples that report the supply under the lowest threshold. When the run is long enough, the block raises the reset request. It keeps the request raised until a sample shows the supply back at the higher recovery threshold. This gap between the trip level and the release level stops the request from chattering near the trip level.

After a power-on reset the block starts in an initial-sampling state with the request raised. It releases only when a sample reaches the recovery threshold. An early low sample never lets the system run on a weak supply. A static option input decides whether the voltage-based reset is used at all. While the option is off, the request stays low and the block waits in its initial-sampling state.

The sample input is a one-way stream with no back-pressure. The block has no ready signal and accepts every strobe in the cycle it appears. The producer must hold the level code valid in any cycle where the strobe is high. Cycles without a strobe carry no data. Typical producers space samples a few hundred oscillator cycles apart, for example one window of 248 cycles.

Top module: `svm_reset_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters its initial-sampling state with the low-sample run count cleared. With `opt_en` high, `reset_req` reads 1 after that edge.
- R2: While released, `reset_req` rises after the edge that accepts the RUN_LEN-th consecutive sample with code 0 (RUN_LEN = 4 by default). After RUN_LEN-1 such samples it stays low.
- R3: While released, a sample with code 1, 2 or 3 clears the low-sample run count. After it, a full run of RUN_LEN fresh code-0 samples is needed to trip.
- R4: Once raised, `reset_req` stays high through any number of samples with code 0 or 1.
- R5: While `reset_req` is high, a sample with code 2 or 3 drops `reset_req` after the edge that accepts it.
- R6: After power-on, samples below code 2 keep `reset_req` high and sampling continues. The first sample with code 2 or 3 releases it.
- R7: While `opt_en` is low, `reset_req` is 0 whatever the samples, and the block returns to its initial-sampling state. When `opt_en` returns high, `reset_req` is 1 until a sample with code 2 or 3 arrives.
- R8: Cycles with `smp_valid` low change nothing. The output and the low-sample run count keep their values whatever `smp_level` shows.
- R9: Level code meaning: 0 means below level 0, 1 means between level 0 and level 2, and 2 or 3 means at or above level 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| opt_en | input | 1 | Static option that enables the voltage-based reset |
| smp_valid | input | 1 | Sample strobe. One accepted sample per high cycle; no back-pressure |
| smp_level | input | LVL_W (2) | Sampled supply level code, valid while `smp_valid` is high |
| reset_req | output | 1 | Initial reset request, active high |

## Verification
The bench builds the block with its defaults: a 2-bit level code, a run length of four, code 0 as the trip code and code 2 as the recovery code. With a run of four, every boundary is a few strobes away: three low samples against four, a break of the run by code 1 and by code 3, and long idle gaps in the middle of a run. The same defaults let short directed sequences reach the power-on hold, the release on code 2 and on code 3, and the return to the initial-sampling state through the option input.

// File: rtl/svm_pkg.sv
package svm_pkg;
  typedef enum logic [1:0] {
    SVM_INIT    = 2'd0,
    SVM_ARMED   = 2'd1,
    SVM_TRIPPED = 2'd2
  } svm_state_e;
endpackage

// File: rtl/svm_level_class.sv
module svm_level_class #(
  parameter int LVL_W        = 2,
  parameter int LOW_CODE     = 0,
  parameter int RECOVER_CODE = 2
) (
  input  logic [LVL_W-1:0] level,
  output logic             is_low,
  output logic             is_ok
);
  localparam logic [LVL_W-1:0] LOW_L = LVL_W'(LOW_CODE);
  localparam logic [LVL_W-1:0] REC_L = LVL_W'(RECOVER_CODE);

  always_comb begin
    is_low = (level <= LOW_L);
    is_ok  = (level >= REC_L);
  end
endmodule

// File: rtl/svm_low_run.sv
module svm_low_run #(
  parameter int RUN_LEN = 4,
  parameter int CNT_W   = $clog2(RUN_LEN + 1)
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             step,
  input  logic             brk,
  output logic             hit,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

  always_comb hit = step && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (clr || brk || hit) cnt <= '0;
    else if (step)         cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/svm_reset_ctrl.sv
module svm_reset_ctrl
  import svm_pkg::*;
#(
  parameter int LVL_W        = 2,
  parameter int RUN_LEN      = 4,
  parameter int LOW_CODE     = 0,
  parameter int RECOVER_CODE = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             opt_en,
  input  logic             smp_valid,
  input  logic [LVL_W-1:0] smp_level,
  output logic             reset_req
);
  localparam int CNT_W = $clog2(RUN_LEN + 1);

  svm_state_e       state;
  logic             lvl_low, lvl_ok;
  logic             run_step, run_brk, run_clr, run_hit;
  logic [CNT_W-1:0] run_cnt;

  svm_level_class #(
    .LVL_W(LVL_W), .LOW_CODE(LOW_CODE), .RECOVER_CODE(RECOVER_CODE)
  ) u_class (
    .level (smp_level),
    .is_low(lvl_low),
    .is_ok (lvl_ok)
  );

  always_comb begin
    run_clr  = rst || !opt_en || (state != SVM_ARMED);
    run_step = smp_valid && lvl_low && (state == SVM_ARMED);
    run_brk  = smp_valid && !lvl_low;
  end

  svm_low_run #(.RUN_LEN(RUN_LEN), .CNT_W(CNT_W)) u_run (
    .clk (clk),
    .clr (run_clr),
    .step(run_step && opt_en),
    .brk (run_brk),
    .hit (run_hit),
    .cnt (run_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst || !opt_en) begin
      state <= SVM_INIT;
    end else begin
      unique case (state)
        SVM_INIT, SVM_TRIPPED:
          if (smp_valid && lvl_ok) state <= SVM_ARMED;
        SVM_ARMED:
          if (run_hit) state <= SVM_TRIPPED;
        default: state <= SVM_INIT;
      endcase
    end
  end

  always_comb reset_req = opt_en && (state != SVM_ARMED);
endmodule

// File: rtl/svm_reset_chk.sv
module svm_reset_chk #(
  parameter int LVL_W   = 2,
  parameter int RUN_LEN = 4,
  parameter int CNT_W   = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             opt_en,
  input logic             smp_valid,
  input logic [LVL_W-1:0] smp_level,
  input logic             reset_req,
  input logic [CNT_W-1:0] run_cnt
);
  // R4: a raised request holds unless a recovery sample arrives
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    opt_en && reset_req && !(smp_valid && smp_level >= 2) |=> reset_req || !opt_en);

  // R5: a recovery sample releases the request
  p_release_r5: assert property (@(posedge clk) disable iff (rst)
    opt_en && reset_req && smp_valid && smp_level >= 2 |=> !reset_req || !opt_en);

  // R2: a non-low sample never trips a released block
  p_no_trip_r2: assert property (@(posedge clk) disable iff (rst)
    opt_en && !reset_req && smp_valid && smp_level != 0 |=> !reset_req || !opt_en);

  // R3: a non-low sample clears the run count
  p_run_clear_r3: assert property (@(posedge clk) disable iff (rst)
    smp_valid && smp_level != 0 |=> run_cnt == 0);

  // R8: idle cycles change nothing
  p_idle_r8: assert property (@(posedge clk) disable iff (rst)
    opt_en && !smp_valid |=> ($stable(reset_req) && $stable(run_cnt)) || !opt_en);

  // R2: run count never reaches the trip length
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    run_cnt < CNT_W'(RUN_LEN));
endmodule

bind svm_reset_ctrl svm_reset_chk #(.LVL_W(LVL_W), .RUN_LEN(RUN_LEN), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .opt_en(opt_en), .smp_valid(smp_valid),
  .smp_level(smp_level), .reset_req(reset_req), .run_cnt(run_cnt)
);

// File: tb/svm_reset_ctrl_bench.sv
module svm_reset_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       opt_en = 1'b1;
  logic       smp_valid = 1'b0;
  logic [1:0] smp_level = 2'd0;
  logic       reset_req;
  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  svm_reset_ctrl u_svm_reset_ctrl (
    .clk(clk), .rst(rst), .opt_en(opt_en), .smp_valid(smp_valid),
    .smp_level(smp_level), .reset_req(reset_req)
  );

  task automatic check(input string req, input logic exp);
    total++;
    if (reset_req !== exp) begin
      bad++;
      $display("FAIL %s: reset_req=%b expected=%b", req, reset_req, exp);
    end
  endtask

  task automatic sample(input logic [1:0] code);
    smp_valid = 1'b1;
    smp_level = code;
    @(posedge clk);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1; opt_en = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R1", 1'b1);
  endtask

  task automatic t_powerup;
    sample(2'd1); check("R6", 1'b1);
    for (int i = 0; i < 5; i++) begin sample(2'd0); check("R6", 1'b1); end
    sample(2'd2); check("R6", 1'b0);
  endtask

  task automatic t_debounce;
    for (int i = 0; i < 3; i++) begin sample(2'd0); check("R2", 1'b0); end
    sample(2'd0); check("R2", 1'b1);
    sample(2'd3); check("R5 R9", 1'b0);
  endtask

  task automatic t_break(input logic [1:0] brk);
    for (int i = 0; i < 3; i++) sample(2'd0);
    sample(brk); check("R3", 1'b0);
    for (int i = 0; i < 3; i++) begin sample(2'd0); check("R3", 1'b0); end
    sample(2'd0); check("R3", 1'b1);
    sample(2'd2); check("R5", 1'b0);
  endtask

  task automatic t_hold;
    for (int i = 0; i < 4; i++) sample(2'd0);
    check("R4", 1'b1);
    for (int i = 0; i < 3; i++) begin sample(2'd1); check("R4", 1'b1); end
    sample(2'd0); check("R4", 1'b1);
    sample(2'd2); check("R5", 1'b0);
  endtask

  task automatic t_idle;
    for (int i = 0; i < 3; i++) sample(2'd0);
    smp_level = 2'd3;
    repeat (10) @(negedge clk);
    check("R8", 1'b0);
    sample(2'd0); check("R8", 1'b1);
    sample(2'd2); check("R5", 1'b0);
  endtask

  task automatic t_disable;
    opt_en = 1'b0;
    @(negedge clk);
    check("R7", 1'b0);
    for (int i = 0; i < 6; i++) begin sample(2'd0); check("R7", 1'b0); end
    opt_en = 1'b1;
    @(negedge clk);
    check("R7", 1'b1);
    sample(2'd1); check("R7", 1'b1);
    sample(2'd2); check("R7", 1'b0);
  endtask

  initial begin
    @(negedge clk);
    t_reset;
    t_powerup;
    t_debounce;
    t_break(2'd1);
    t_break(2'd3);
    t_hold;
    t_idle;
    t_disable;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule